// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent interval-timer channels. Each channel keeps a reload count, a 3-bit mode and a record of its gate level. It also tracks the number of clock ticks, called d, since its count was last loaded or restarted. Each channel's output is a fixed function of d, the reload count and the mode. That gives level, one-shot, rate, square-wave and strobe behaviour without a separate down-counter per mode. Every rising clock edge is one tick.

A host programs a channel through a single-beat configuration port. Each beat carries a channel index, a mode and a 16-bit count, and loads both the mode and the count together. The port uses valid/ready. `cfg_ready` is held high, so the block never applies back-pressure and a beat is taken on every cycle in which `cfg_valid` is high. Channel 0's output drives the interrupt request, which an external mask input can force low.

Top module: `ptimer_top`

## Requirements
- R1: A count field of 0 loads a reload value of 65536. Elapsed ticks are compared against that full value.
- R2: Mode 0 holds the output low while d < count, and high once d >= count.
- R3: Mode 1 drives the output high while d < count and low afterwards. After a count write, d stays frozen at 0 until a gate rising edge arrives, so the output stays high.
- R4: Mode 2 raises the output for one tick whenever d is a nonzero multiple of the count, and keeps it low at every other tick.
- R5: Mode 3 is high while (d mod count) < floor((count+1)/2), and low for the rest of each period.
- R6: Modes 4 and 5 give a single one-tick high strobe at d == count, with the output low before and after it. After a count write, mode 5 keeps d frozen at 0 until a gate rising edge arrives.
- R7: A gate rising edge clears d to 0 in modes 1, 2, 3 and 5. In modes 0 and 4 the gate level is recorded but has no effect on the output.
- R8: A configuration beat to a channel clears its d to 0 in the same cycle. A beat and a gate edge in the same cycle are handled as the beat.
- R9: Reset leaves every channel in mode 3 with count 65536 and d = 0. The recorded gate is high for channels 0 and 1 and low for channel 2, so channel 2 sees a rising edge if its gate input is high after reset.
- R10: `irq` equals channel 0's output while `irq_mask` is 0, and is 0 while `irq_mask` is 1.
- R11: Mode codes 6 and 7 behave exactly as mode 0.
- R12: `cfg_ready` is always 1. Channel indices 0, 1 and 2 select a channel, and index 3 is ignored with no channel's state changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one timer tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration beat present |
| cfg_ready | output | 1 | Always high; the beat is taken when valid |
| cfg_chan | input | 2 | Target channel (0..2; 3 ignored) |
| cfg_mode | input | 3 | Mode code 0..7 |
| cfg_count | input | 16 | Reload count (0 means 65536) |
| gate_in | input | 3 | Gate level per channel |
| irq_mask | input | 1 | Forces the interrupt request low |
| timer_out | output | 3 | Output per channel |
| irq | output | 1 | Interrupt request from channel 0 |

## Verification
A reference model in the bench tracks d as an unbounded integer and applies each mode rule with true modulo arithmetic. The outputs are compared against it on every cycle. Short counts (1, 2, 3) separate the off-by-one cases in mode 2 and mode 3, and odd versus even counts show the rounding of the mode 3 high phase. Gate pulses sent to each mode separate the retriggering modes from those that only record the gate. A count of 0 run past 65536 ticks, and the long run after reset, show the full-range reload and the asymmetric gate defaults, because channel 2 switches one tick later than channel 0.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  localparam int CNT_W  = 16;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MD_DELAY_HIGH  = 3'd0;
  localparam logic [MODE_W-1:0] MD_ONESHOT     = 3'd1;
  localparam logic [MODE_W-1:0] MD_RATE        = 3'd2;
  localparam logic [MODE_W-1:0] MD_SQUARE      = 3'd3;
  localparam logic [MODE_W-1:0] MD_SOFT_STROBE = 3'd4;
  localparam logic [MODE_W-1:0] MD_GATED_STROBE = 3'd5;

  // Modes whose elapsed tick count restarts on a gate rising edge
  function automatic logic gate_retriggers(input logic [MODE_W-1:0] m);
    return (m == MD_ONESHOT) || (m == MD_RATE) ||
           (m == MD_SQUARE)  || (m == MD_GATED_STROBE);
  endfunction

  // Modes that stay frozen after a count write until a gate edge arrives
  function automatic logic waits_for_gate(input logic [MODE_W-1:0] m);
    return (m == MD_ONESHOT) || (m == MD_GATED_STROBE);
  endfunction

endpackage

// File: rtl/ptimer_out_rule.sv
module ptimer_out_rule
  import ptimer_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [CW:0]       count,
  input  logic [CW:0]       elapsed,
  input  logic [CW:0]       phase,
  output logic              out
);

  logic [CW+1:0] half_sum;
  logic [CW:0]   half;

  // Length of the square-wave high phase: floor((count+1)/2)
  assign half_sum = {1'b0, count} + {{(CW+1){1'b0}}, 1'b1};
  assign half     = half_sum[CW+1:1];

  always_comb begin
    unique case (mode)
      MD_ONESHOT:      out = (elapsed < count);
      MD_RATE:         out = (phase == '0) && (elapsed != '0);
      MD_SQUARE:       out = (phase < half);
      MD_SOFT_STROBE,
      MD_GATED_STROBE: out = (elapsed == count);
      default:         out = (elapsed >= count);
    endcase
  end

endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan
  import ptimer_pkg::*;
#(
  parameter int   CW        = CNT_W,
  parameter logic GATE_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] load_mode,
  input  logic [CW-1:0]     load_cnt,
  input  logic              gate,
  output logic              out
);

  localparam int VW = CW + 1;
  localparam logic [VW-1:0] FULL_CNT = VW'(1) << CW;
  localparam logic [VW-1:0] ONE      = VW'(1);

  logic [MODE_W-1:0] mode_q;
  logic [VW-1:0]     count_q;
  logic [VW-1:0]     elapsed_q;
  logic [VW-1:0]     phase_q;
  logic              hold_q;
  logic              gate_q;

  logic [VW-1:0] count_eff;
  logic          gate_rise;
  logic          trig;
  logic          elapsed_sat;
  logic          phase_wrap;

  assign count_eff   = (load_cnt == '0) ? FULL_CNT : {1'b0, load_cnt};
  assign gate_rise   = gate & ~gate_q;
  assign trig        = gate_rise & gate_retriggers(mode_q);
  assign elapsed_sat = (elapsed_q == count_q + ONE);
  assign phase_wrap  = (phase_q == count_q - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_SQUARE;
      count_q   <= FULL_CNT;
      elapsed_q <= '0;
      phase_q   <= '0;
      hold_q    <= 1'b0;
      gate_q    <= GATE_INIT;
    end else begin
      gate_q <= gate;
      if (load) begin
        mode_q    <= load_mode;
        count_q   <= count_eff;
        elapsed_q <= '0;
        phase_q   <= '0;
        hold_q    <= waits_for_gate(load_mode);
      end else if (trig) begin
        elapsed_q <= '0;
        phase_q   <= '0;
        hold_q    <= 1'b0;
      end else if (!hold_q) begin
        if (!elapsed_sat) elapsed_q <= elapsed_q + ONE;
        phase_q <= phase_wrap ? '0 : phase_q + ONE;
      end
    end
  end

  ptimer_out_rule #(.CW(CW)) u_rule (
    .mode    (mode_q),
    .count   (count_q),
    .elapsed (elapsed_q),
    .phase   (phase_q),
    .out     (out)
  );

  // R2
  delay_high_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_DELAY_HIGH && out && !load) |=> out);

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_SOFT_STROBE || mode_q == MD_GATED_STROBE) && out && !load && !trig)
      |=> !out);

  // R4
  rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RATE && out && count_q > ONE && !load && !trig) |=> !out);

  // R3
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !load && !gate_rise) |=> $stable(elapsed_q));

  // R8
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (elapsed_q == '0 && phase_q == '0));

endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int              NUM_CH   = 3,
  parameter int              CW       = CNT_W,
  parameter logic [NUM_CH-1:0] GATE_RST = 3'b011
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_valid,
  output logic                      cfg_ready,
  input  logic [$clog2(NUM_CH+1)-1:0] cfg_chan,
  input  logic [MODE_W-1:0]         cfg_mode,
  input  logic [CW-1:0]             cfg_count,
  input  logic [NUM_CH-1:0]         gate_in,
  input  logic                      irq_mask,
  output logic [NUM_CH-1:0]         timer_out,
  output logic                      irq
);

  localparam int SEL_W = $clog2(NUM_CH + 1);

  logic [NUM_CH-1:0] load;

  assign cfg_ready = 1'b1;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign load[i] = cfg_valid && cfg_ready && (cfg_chan == SEL_W'(i));

    ptimer_chan #(
      .CW        (CW),
      .GATE_INIT (GATE_RST[i])
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load[i]),
      .load_mode (cfg_mode),
      .load_cnt  (cfg_count),
      .gate      (gate_in[i]),
      .out       (timer_out[i])
    );
  end

  assign irq = timer_out[0] & ~irq_mask;

  // R12
  one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (timer_out[0] && !irq_mask));

endmodule

// File: tb/ptimer_top_tb.sv
module ptimer_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_valid;
  logic        cfg_ready;
  logic [1:0]  cfg_chan;
  logic [2:0]  cfg_mode;
  logic [15:0] cfg_count;
  logic [2:0]  gate_in;
  logic        irq_mask;
  logic [2:0]  timer_out;
  logic        irq;

  int n_cmp  = 0;
  int n_bad  = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ptimer_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .cfg_chan  (cfg_chan),
    .cfg_mode  (cfg_mode),
    .cfg_count (cfg_count),
    .gate_in   (gate_in),
    .irq_mask  (irq_mask),
    .timer_out (timer_out),
    .irq       (irq)
  );

  // Reference model: d as unbounded integer per channel
  int m_d[3];
  int m_c[3];
  int m_m[3];
  bit m_h[3];
  bit m_g[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_d[i] = 0; m_c[i] = 65536; m_m[i] = 3; m_h[i] = 0; m_g[i] = (i != 2);
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        bit rise;
        rise = gate_in[i] && !m_g[i];
        if (cfg_valid && cfg_chan == 2'(i)) begin
          m_m[i] = cfg_mode;
          m_c[i] = (cfg_count == 0) ? 65536 : int'(cfg_count);
          m_d[i] = 0;
          m_h[i] = (cfg_mode == 1 || cfg_mode == 5);
        end else if (rise && (m_m[i] == 1 || m_m[i] == 2 || m_m[i] == 3 || m_m[i] == 5)) begin
          m_d[i] = 0;
          m_h[i] = 0;
        end else if (!m_h[i]) begin
          m_d[i] = m_d[i] + 1;
        end
        m_g[i] = gate_in[i];
      end
    end
  end

  function automatic bit exp_out(int i);
    int d, c;
    d = m_d[i]; c = m_c[i];
    case (m_m[i])
      1:       return d < c;
      2:       return (d != 0) && (d % c == 0);
      3:       return (d % c) < ((c + 1) / 2);
      4, 5:    return d == c;
      default: return d >= c;
    endcase
  endfunction

  function automatic string tag_of(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic cmp(string tag);
    bit ok;
    bit e;
    ok = 1;
    for (int i = 0; i < 3; i++) begin
      e = exp_out(i);
      if (timer_out[i] !== e) begin
        ok = 0;
        $display("FAIL %s ch%0d out actual=%0b expected=%0b (d=%0d)", tag, i, timer_out[i], e, m_d[i]);
      end
    end
    e = exp_out(0) & ~irq_mask;
    if (irq !== e) begin
      ok = 0;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
    n_cmp++;
    if (!ok) n_bad++;
  endtask

  task automatic check1(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp(tag);
    end
  endtask

  task automatic write(int ch, int mode, int cnt, string tag);
    cfg_valid = 1'b1;
    cfg_chan  = 2'(ch);
    cfg_mode  = 3'(mode);
    cfg_count = 16'(cnt);
    @(negedge clk);
    cmp(tag);
    cfg_valid = 1'b0;
  endtask

  task automatic gate_pulse(int ch, string tag);
    gate_in[ch] = 1'b0;
    @(negedge clk);
    cmp(tag);
    gate_in[ch] = 1'b1;
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // {chan[31:30], mode[29:27], count[26:11], cycles[10:0]}
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 3'd0, 16'd5,  11'd20},
    {2'd1, 3'd2, 16'd4,  11'd30},
    {2'd2, 3'd3, 16'd7,  11'd40},
    {2'd0, 3'd3, 16'd6,  11'd30},
    {2'd1, 3'd4, 16'd3,  11'd12},
    {2'd2, 3'd2, 16'd1,  11'd10},
    {2'd0, 3'd6, 16'd4,  11'd12},
    {2'd1, 3'd7, 16'd2,  11'd10},
    {2'd0, 3'd3, 16'd1,  11'd8},
    {2'd2, 3'd3, 16'd2,  11'd12}
  };

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
        report();
      end
    end
  end

  initial begin
    rst_n = 1'b0; cfg_valid = 1'b0; cfg_chan = '0; cfg_mode = '0;
    cfg_count = '0; gate_in = 3'b111; irq_mask = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state, mode 3 with full count -> all high
    check1("R9 timer_out", timer_out[0] & timer_out[1] & timer_out[2], 1'b1);
    check1("R12 cfg_ready", cfg_ready, 1'b1);
    cmp("R9");
    // R9: channel 2 restarts on first edge and trails by one tick
    run(40000, "R9");

    for (int v = 0; v < NV; v++) begin
      int ch, md, ct, cy;
      ch = int'(VEC[v][31:30]);
      md = int'(VEC[v][29:27]);
      ct = int'(VEC[v][26:11]);
      cy = int'(VEC[v][10:0]);
      write(ch, md, ct, tag_of(md));
      run(cy, tag_of(md));
    end

    // R3: mode 1 frozen high until gate edge
    write(1, 1, 4, "R3");
    run(6, "R3");
    check1("R3 held high", timer_out[1], 1'b1);
    gate_pulse(1, "R3");
    run(8, "R3");
    check1("R3 low after count", timer_out[1], 1'b0);

    // R6: mode 5 frozen until gate edge, then one strobe
    write(2, 5, 3, "R6");
    run(5, "R6");
    gate_pulse(2, "R6");
    run(6, "R6");

    // R7: gate ignored in mode 0 and 4, restarts in mode 2
    write(0, 0, 8, "R7");
    run(3, "R7");
    gate_pulse(0, "R7");
    run(8, "R7");
    write(1, 4, 6, "R7");
    run(2, "R7");
    gate_pulse(1, "R7");
    run(8, "R7");
    write(1, 2, 5, "R7");
    run(7, "R7");
    gate_pulse(1, "R7");
    run(8, "R7");

    // R8: rewrite restarts the delay
    write(0, 0, 10, "R8");
    run(6, "R8");
    write(0, 0, 10, "R8");
    run(12, "R8");

    // R10: mask forces irq low
    write(0, 0, 2, "R10");
    run(4, "R10");
    irq_mask = 1'b1;
    run(3, "R10");
    check1("R10 masked irq", irq, 1'b0);
    irq_mask = 1'b0;
    run(2, "R10");
    check1("R10 unmasked irq", irq, 1'b1);

    // R12: channel index 3 ignored
    write(3, 1, 1, "R12");
    run(5, "R12");
    check1("R12 ch0 unchanged", timer_out[0], 1'b1);

    // R1: count 0 means 65536 (mode 4 strobe at d=65536)
    write(1, 4, 0, "R1");
    run(65540, "R1");

    done = 1;
    report();
  end

endmodule